// File: doc/BRIEF.md
# Timer Tick Generator

This block turns one base clock into a set of single-cycle tick enables, one per timer channel, for a five-channel timer. The channels form two groups. Channels 0 and 1 share one 8-bit prescaler, and channels 2 to 4 share a second one. A prescaler value P produces a group tick on every (P+1)-th base cycle. Each channel has a 4-bit selector. The selector either picks a power-of-two division of its group tick or follows an external clock pin owned by its group. The external clock is synchronised and edge-detected first.

The timers consume the ticks as clock enables, so every timer runs in the base clock domain. Prescaler values arrive with a per-group write strobe. A write restarts that group's counting, which gives software a known phase after reprogramming. The selector word is a static configuration input, and its decode is purely combinational. Two parameters set the variant: `DIV_BASE` is a fixed exponent offset added to every division, and `EXT_MASK` lists which selector codes choose the external clock.

Top module: `tmr_tick_gen`

## Requirements
- R1: While `rstN` is low every tick is 0. Reset clears both prescaler values to 0, so with selector code 0 on every channel all ticks are 1 in every cycle after reset.
- R2: A prescaler value P makes a group tick on every (P+1)-th base clock cycle.
- R3: `preCfgIn[7:0]` with `preWe[0]` loads the prescaler of channels 0 and 1. `preCfgIn[15:8]` with `preWe[1]` loads the prescaler of channels 2 to 4. A write to one group leaves the tick spacing of the other group unchanged.
- R4: The selector of channel c is read from `selCfg[4c+3:4c]`.
- R5: A selector code s that is not marked in `EXT_MASK` gives a tick period of 2^(s+DIV_BASE)·(P+1) cycles. This holds for all codes, including 8 and 15. When s+DIV_BASE is at least 1, a tick never lasts two consecutive cycles.
- R6: A code s whose bit `EXT_MASK[s]` is set makes the channel follow its group's external clock. Channels 0 and 1 use `extClk[0]` and channels 2 to 4 use `extClk[1]`. With the default mask (bits 5, 6 and 7 set), codes 5 to 7 are external and code 4 is a division.
- R7: Each rising edge on an external clock gives exactly one single-cycle tick on every channel that selects it, about three base cycles later. Falling edges give no tick.
- R8: The clock edge that takes a prescaler write resets that group's prescaler counter and its divider counter. Take the cycle after that edge as cycle 0. A channel with division exponent k then gives its first tick in cycle 2^k·(P+1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preCfgIn | input | 16 | Prescaler values: group 0 in bits 7:0, group 1 in bits 15:8 |
| preWe | input | 2 | Per-group prescaler write strobe |
| selCfg | input | 20 | Per-channel 4-bit selectors, channel c at bits 4c+3:4c |
| extClk | input | 2 | External clocks, asynchronous: bit 0 for group 0, bit 1 for group 1 |
| tick | output | 5 | Single-cycle tick enable per channel |

## Verification
If a prescaler or divider counter holds a wrong value, the first tick after a write lands in the wrong cycle. The bench therefore measures the index of the first tick and the spacing to the second tick, and a counting fault shows up within one tick period. A fault in the grouping or in the selector-field decode shifts the period of the wrong channel, so the error appears on the first measurement of that channel. A faulty synchroniser or edge detector changes the number of ticks counted across a burst of external edges, and the error is visible within a few cycles of each edge.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Control-to-datapath strobes, one bit per channel group.
  typedef struct packed {
    logic [1:0] preTick;  // group prescaler reached its terminal count
    logic [1:0] restart;  // group prescaler was written this cycle
  } tickStrobe_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*PRE_W-1:0] preCfgIn,
  input  logic [1:0]         preWe,
  output tickStrobe_t        strobe
);
  logic       liveQ;
  logic [1:0] preTickV;

  // Ticks stay quiet until the first clock edge after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= 1'b0;
    else       liveQ <= 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_pre
    logic [PRE_W-1:0] valQ;
    logic [PRE_W-1:0] cntQ;
    logic             hit;

    assign hit = (cntQ == valQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ <= '0;
        cntQ <= '0;
      end else if (preWe[g]) begin
        valQ <= preCfgIn[g*PRE_W +: PRE_W];
        cntQ <= '0;
      end else if (hit) begin
        cntQ <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end

    assign preTickV[g] = liveQ & hit;
  end

  assign strobe = '{preTick: preTickV, restart: preWe};
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int                      NUM_CH   = 5,
  parameter int                      GRP0_CH  = 2,
  parameter int                      SEL_W    = 4,
  parameter int                      DIV_BASE = 0,
  parameter logic [(1<<SEL_W)-1:0]   EXT_MASK = 16'h00E0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tickStrobe_t             strobe,
  input  logic [NUM_CH*SEL_W-1:0] selCfg,
  input  logic [1:0]              extClk,
  output logic [NUM_CH-1:0]       tick
);
  localparam int             TAP_W  = (1 << SEL_W) - 1 + DIV_BASE;
  localparam logic [SEL_W:0] BASE_K = DIV_BASE[SEL_W:0];

  logic [TAP_W-1:0] tapQ [2];
  logic [1:0]       syncA, syncB, syncC;
  logic [1:0]       extTick;

  // Ones in the k low bits select the divider tap for 2^k.
  function automatic logic [TAP_W-1:0] lowMask(input logic [SEL_W:0] k);
    logic [TAP_W-1:0] m;
    for (int i = 0; i < TAP_W; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  // Free-running divider counters, advanced by the group prescaler tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < 2; g++) tapQ[g] <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (strobe.restart[g])      tapQ[g] <= '0;
        else if (strobe.preTick[g]) tapQ[g] <= tapQ[g] + 1'b1;
      end
    end
  end

  // Two-flop synchroniser plus one edge-detect stage per external clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= extClk;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign extTick = syncB & ~syncC;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;
    logic [SEL_W-1:0] sel;
    logic [SEL_W:0]   kExp;
    logic             divHit;

    assign sel    = selCfg[c*SEL_W +: SEL_W];
    assign kExp   = {1'b0, sel} + BASE_K;
    assign divHit = strobe.preTick[GRP] & (&(tapQ[GRP] | ~lowMask(kExp)));
    assign tick[c] = EXT_MASK[sel] ? extTick[GRP] : divHit;
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tick_pkg::*;
#(
  parameter int                    NUM_CH   = 5,
  parameter int                    GRP0_CH  = 2,
  parameter int                    PRE_W    = 8,
  parameter int                    SEL_W    = 4,
  parameter int                    DIV_BASE = 0,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h00E0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*PRE_W-1:0]      preCfgIn,
  input  logic [1:0]              preWe,
  input  logic [NUM_CH*SEL_W-1:0] selCfg,
  input  logic [1:0]              extClk,
  output logic [NUM_CH-1:0]       tick
);
  tickStrobe_t strobe;

  tick_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .preCfgIn (preCfgIn),
    .preWe    (preWe),
    .strobe   (strobe)
  );

  tick_datapath #(
    .NUM_CH   (NUM_CH),
    .GRP0_CH  (GRP0_CH),
    .SEL_W    (SEL_W),
    .DIV_BASE (DIV_BASE),
    .EXT_MASK (EXT_MASK)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .selCfg (selCfg),
    .extClk (extClk),
    .tick   (tick)
  );
endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk #(
  parameter int                    NUM_CH   = 5,
  parameter int                    GRP0_CH  = 2,
  parameter int                    PRE_W    = 8,
  parameter int                    SEL_W    = 4,
  parameter int                    DIV_BASE = 0,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h00E0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2*PRE_W-1:0]      preCfgIn,
  input logic [1:0]              preWe,
  input logic [NUM_CH*SEL_W-1:0] selCfg,
  input logic [1:0]              extClk,
  input logic [NUM_CH-1:0]       tick
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> (tick == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;
    logic [SEL_W-1:0] sel;
    logic             isExt;
    logic [SEL_W:0]   kExp;

    assign sel   = selCfg[c*SEL_W +: SEL_W];
    assign isExt = EXT_MASK[sel];
    assign kExp  = {1'b0, sel} + DIV_BASE[SEL_W:0];

    // R8
    restart_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (preWe[GRP] && (preCfgIn[GRP*PRE_W +: PRE_W] != '0) && !isExt)
      |=> (!tick[c] || isExt));

    // R5
    div_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!isExt && (kExp != '0) && tick[c]) |=> (!tick[c] || !$stable(selCfg)));

    // R7
    ext_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      (isExt && tick[c]) |=> (!tick[c] || !$stable(selCfg)));

    // R6
    ext_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((sinceRst == 2'd3) && isExt && tick[c])
      |-> ($past(extClk[GRP], 2) && !$past(extClk[GRP], 3)));
  end
endmodule

bind tmr_tick_gen tick_gen_chk #(
  .NUM_CH   (NUM_CH),
  .GRP0_CH  (GRP0_CH),
  .PRE_W    (PRE_W),
  .SEL_W    (SEL_W),
  .DIV_BASE (DIV_BASE),
  .EXT_MASK (EXT_MASK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .preCfgIn (preCfgIn),
  .preWe    (preWe),
  .selCfg   (selCfg),
  .extClk   (extClk),
  .tick     (tick)
);

// File: tb/tmr_tick_gen_tb.sv
module tmr_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] preCfgIn;
  logic [1:0]  preWe;
  logic [19:0] selCfg;
  logic [1:0]  extClk;
  logic [4:0]  tick;

  int nChecks = 0;
  int nErrs   = 0;
  logic   countOn = 1'b0;
  int     tickCnt [5];

  always #10 clk = ~clk;

  tmr_tick_gen u_dut (
    .clk(clk), .rstN(rstN), .preCfgIn(preCfgIn), .preWe(preWe),
    .selCfg(selCfg), .extClk(extClk), .tick(tick)
  );

  always @(negedge clk) begin
    if (countOn)
      for (int c = 0; c < 5; c++) tickCnt[c] += int'(tick[c]);
  end

  function automatic int expFirst(input int p, input int k);
    return ((p + 1) << k) - 1;
  endfunction

  function automatic int expPeriod(input int p, input int k);
    return (p + 1) << k;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setSel(input int ch, input int code);
    selCfg[ch*4 +: 4] = code[3:0];
  endtask

  // Leaves the bench at the negedge that starts cycle 0 after the write edge.
  task automatic writePre(input int g, input int val);
    @(negedge clk);
    preCfgIn[g*8 +: 8] = val[7:0];
    preWe[g] = 1'b1;
    @(negedge clk);
    preWe = '0;
  endtask

  task automatic measure(input int ch, input int limit, output int first, output int second);
    first = -1;
    second = -1;
    for (int idx = 0; idx < limit; idx++) begin
      if (tick[ch]) begin
        if (first < 0) first = idx;
        else begin
          second = idx;
          break;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic runExt(input int g, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClk[g] = 1'b1;
      repeat (3) @(negedge clk);
      extClk[g] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(20 * 180000);
    nErrs++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    int f, s, ch, p, code, grp;
    void'($urandom(32'd4711));
    rstN = 1'b0; preCfgIn = '0; preWe = '0; selCfg = '0; extClk = '0;

    // R1 quiet during reset
    repeat (3) begin
      @(negedge clk);
      check(tick == 5'h00, "R1 reset ticks", int'(tick), 0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(tick == 5'h1F, "R1 post-reset divide-by-one", int'(tick), 31);
      @(negedge clk);
    end

    // R2 / R8: group 1 prescaler 3, channel 2 code 0
    writePre(1, 3);
    measure(2, 64, f, s);
    check(f == 3, "R8 first tick ch2", f, 3);
    check(s - f == 4, "R2 period ch2", s - f, 4);

    // R3: group 0 write, channel 0 follows bits 7:0
    writePre(0, 5);
    measure(0, 64, f, s);
    check(f == 5, "R3 first tick ch0", f, 5);
    check(s - f == 6, "R3 period ch0", s - f, 6);
    // R3: group 0 write leaves group 1 spacing alone
    writePre(0, 6);
    measure(4, 64, f, s);
    check(s - f == 4, "R3 group1 period unaffected", s - f, 4);

    // R8: a rewrite mid-count restarts the phase
    writePre(0, 4);
    repeat (2) @(negedge clk);
    writePre(0, 4);
    measure(1, 64, f, s);
    check(f == 4, "R8 restart mid-count ch1", f, 4);

    // R4: field of channel 3 only
    selCfg = '0; setSel(3, 2);
    writePre(1, 1);
    measure(3, 64, f, s);
    check(f == expFirst(1, 2), "R4 ch3 field first", f, expFirst(1, 2));
    check(s - f == expPeriod(1, 2), "R4 ch3 field period", s - f, expPeriod(1, 2));
    writePre(1, 1);
    measure(2, 64, f, s);
    check(f == 1, "R4 ch2 unaffected by ch3 field", f, 1);

    // R5 / R6: code 4 is a division under the default mask
    setSel(2, 4);
    writePre(1, 2);
    measure(2, 256, f, s);
    check(f == expFirst(2, 4), "R6 code4 divides first", f, expFirst(2, 4));
    check(s - f == expPeriod(2, 4), "R5 code4 period", s - f, expPeriod(2, 4));

    // R5 boundaries: code 8 and code 15
    setSel(1, 8);
    writePre(0, 0);
    measure(1, 1024, f, s);
    check(f == 255, "R5 code8 first", f, 255);
    check(s - f == 256, "R5 code8 period", s - f, 256);
    setSel(0, 15);
    writePre(0, 0);
    measure(0, 70000, f, s);
    check(f == 32767, "R5 code15 first", f, 32767);
    check(s - f == 32768, "R5 code15 period", s - f, 32768);

    // Random division settings
    for (int it = 0; it < 24; it++) begin
      ch   = $urandom_range(0, 4);
      p    = $urandom_range(0, 9);
      code = $urandom_range(0, 4);
      grp  = (ch < 2) ? 0 : 1;
      for (int c = 0; c < 5; c++) setSel(c, $urandom_range(0, 15));
      setSel(ch, code);
      writePre(grp, p);
      measure(ch, 512, f, s);
      check(f == expFirst(p, code), "R5 random first", f, expFirst(p, code));
      check(s - f == expPeriod(p, code), "R8 random period", s - f, expPeriod(p, code));
    end

    // R6 / R7: external clocks
    setSel(0, 7); setSel(1, 5); setSel(2, 0); setSel(3, 1); setSel(4, 6);
    @(negedge clk);
    for (int c = 0; c < 5; c++) tickCnt[c] = 0;
    countOn = 1'b1;
    runExt(0, 3);
    countOn = 1'b0;
    check(tickCnt[0] == 3, "R7 ch0 ext0 edges", tickCnt[0], 3);
    check(tickCnt[1] == 3, "R7 ch1 ext0 edges", tickCnt[1], 3);
    check(tickCnt[4] == 0, "R6 ch4 ignores ext0", tickCnt[4], 0);
    @(negedge clk);
    for (int c = 0; c < 5; c++) tickCnt[c] = 0;
    countOn = 1'b1;
    runExt(1, 2);
    countOn = 1'b0;
    check(tickCnt[4] == 2, "R7 ch4 ext1 edges", tickCnt[4], 2);
    check(tickCnt[0] == 0, "R6 ch0 ignores ext1", tickCnt[0], 0);
    check(tickCnt[1] == 0, "R6 ch1 ignores ext1", tickCnt[1], 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule